// File: doc/BRIEF.md
# Chainable TDM Output Node

This block is the serial output stage of one node in a time-division-multiplexed audio chain. When a frame pulse arrives, the node captures one left and one right sample into a 64-bit register, formatted as two 32-bit slots. On every following bit clock the register shifts one bit out on its serial output and takes one bit in from its serial input.

Nodes are chained by wiring each node's serial output to the serial input of the node nearer the host. All nodes share one frame pulse, so the chain acts as one long shift register. The host reads the nearest node's two slots first, then the next node's two slots, and so on. With N nodes the bit clock runs at N×64 times the sample rate.

The node can produce the frame pulse itself (master) or follow an external one (slave). In master mode the pulse repeats every CHAIN_LEN×64 bit clocks, which is 256 with the default chain of four. Each sample is 16 to 24 bits long. An optional auxiliary byte can fill the bottom of each slot.

Top module: `tdm_chain_node`

## Requirements
- R1: While `rst` is high at a clock edge, both `sdata_out` and `frame_out` are 0 after that edge.
- R2: When a load happens at a clock edge, `sdata_out` shows bit 31 of the left slot after that edge. Over the next 63 edges it shows the rest of the left slot and then the right slot, bit 31 down to bit 0, one bit per clock.
- R3: A slot holds the low L bits of its sample word in slot bits 31 down to 32−L, sample MSB first. Every slot bit below 32−L is 0, except the auxiliary byte of R5.
- R4: A `word_len` below 16 is treated as L=16. A `word_len` above 24 is treated as L=24.
- R5: With `aux_en`=1, slot bits 7..0 carry that channel's auxiliary byte, bit 7 first. With `aux_en`=0 those bits are 0.
- R6: When no load happens, each clock edge shifts `tdm_in` into the register. A bit taken in from `tdm_in` appears on `sdata_out` 64 clocks later.
- R7: On a load edge the parallel load wins. The `tdm_in` bit present at that edge is dropped and never reaches `sdata_out`.
- R8: With `master_en`=1, `frame_out` is a pulse one clock wide that repeats every CHAIN_LEN×64 (256) clocks. The node loads on its own pulse and ignores `frame_in`.
- R9: With `master_en`=0, `frame_out` stays 0 and the node loads on each clock edge where `frame_in` is 1.
- R10: In a chain of four nodes sharing one frame pulse, the host reads node 0's left and right slots first, then node 1's, node 2's and node 3's, in chain order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1 = generate the frame pulse, 0 = follow `frame_in` |
| frame_in | input | 1 | External frame pulse, used in slave mode |
| frame_out | output | 1 | Frame pulse generated in master mode |
| word_len | input | 5 | Sample length L in bits (clamped to 16..24) |
| aux_en | input | 1 | Put the auxiliary bytes in slot bits 7..0 |
| left_word | input | 24 | Left sample, valid bits aligned to bit 0 |
| right_word | input | 24 | Right sample, valid bits aligned to bit 0 |
| left_aux | input | 8 | Auxiliary byte for the left slot |
| right_aux | input | 8 | Auxiliary byte for the right slot |
| tdm_in | input | 1 | Serial input from the node farther down the chain |
| sdata_out | output | 1 | Serial output toward the host |

## Verification
A wrong bit in the shift register shows up on `sdata_out` at a fixed delay: within 64 clocks for this node's own content, and within 256 clocks for content passing through the whole chain. The bench therefore stamps every expected bit with the exact cycle it is due. A packing error (wrong length clamp, wrong alignment, or a missing auxiliary byte) shows up within the first 32 bits after a load. A bad frame counter shows up within one period, as a pulse gap other than 256 or as slots from the wrong nodes in the host stream.

// File: rtl/tdm_node_pkg.sv
`timescale 1ns/1ps
package tdm_node_pkg;
  localparam int CH_NUM = 2;   // left, right
  localparam int CH_LEFT  = 0;
  localparam int CH_RIGHT = 1;
endpackage

// File: rtl/tdm_slot_pack.sv
`timescale 1ns/1ps
module tdm_slot_pack #(
  parameter int SLOT_W   = 32,
  parameter int AUX_W    = 8,
  parameter int WORD_MIN = 16,
  parameter int WORD_MAX = SLOT_W - AUX_W,
  parameter int LEN_W    = $clog2(WORD_MAX + 1)
) (
  input  logic [WORD_MAX-1:0] sample,
  input  logic [AUX_W-1:0]    aux,
  input  logic [LEN_W-1:0]    len,
  input  logic                aux_en,
  output logic [SLOT_W-1:0]   slot
);
  logic [LEN_W-1:0]  len_c;
  logic [SLOT_W-1:0] body;

  always_comb begin
    if (len < LEN_W'(WORD_MIN))      len_c = LEN_W'(WORD_MIN);
    else if (len > LEN_W'(WORD_MAX)) len_c = LEN_W'(WORD_MAX);
    else                             len_c = len;
    // move sample bit len-1 up to the slot MSB; lower slot bits fill with zeros
    body = {sample, {AUX_W{1'b0}}} << (LEN_W'(WORD_MAX) - len_c);
    slot = body | (aux_en ? {{WORD_MAX{1'b0}}, aux} : '0);
  end
endmodule

// File: rtl/tdm_frame_gen.sv
`timescale 1ns/1ps
module tdm_frame_gen #(
  parameter int PERIOD = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic master_en,
  output logic pulse
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= master_en && (cnt == LAST);
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_shift_reg.sv
`timescale 1ns/1ps
module tdm_shift_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic         ser_out
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= par_in;
    else           q <= {q[W-2:0], ser_in};
  end

  assign ser_out = q[W-1];
endmodule

// File: rtl/tdm_chain_node.sv
`timescale 1ns/1ps
module tdm_chain_node
  import tdm_node_pkg::*;
#(
  parameter int SLOT_W    = 32,
  parameter int AUX_W     = 8,
  parameter int WORD_MIN  = 16,
  parameter int CHAIN_LEN = 4,
  localparam int WORD_MAX = SLOT_W - AUX_W,
  localparam int LEN_W    = $clog2(WORD_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_en,
  input  logic                frame_in,
  output logic                frame_out,
  input  logic [LEN_W-1:0]    word_len,
  input  logic                aux_en,
  input  logic [WORD_MAX-1:0] left_word,
  input  logic [WORD_MAX-1:0] right_word,
  input  logic [AUX_W-1:0]    left_aux,
  input  logic [AUX_W-1:0]    right_aux,
  input  logic                tdm_in,
  output logic                sdata_out
);
  localparam int REG_W  = CH_NUM * SLOT_W;
  localparam int PERIOD = CHAIN_LEN * REG_W;

  logic [WORD_MAX-1:0] ch_word [CH_NUM];
  logic [AUX_W-1:0]    ch_aux  [CH_NUM];
  logic [SLOT_W-1:0]   ch_slot [CH_NUM];
  logic [REG_W-1:0]    par_frame;
  logic [REG_W-1:0]    frame_bits;
  logic                gen_pulse;
  logic                load;

  assign ch_word[CH_LEFT]  = left_word;
  assign ch_word[CH_RIGHT] = right_word;
  assign ch_aux[CH_LEFT]   = left_aux;
  assign ch_aux[CH_RIGHT]  = right_aux;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    tdm_slot_pack #(
      .SLOT_W(SLOT_W), .AUX_W(AUX_W), .WORD_MIN(WORD_MIN),
      .WORD_MAX(WORD_MAX), .LEN_W(LEN_W)
    ) u_pack (
      .sample(ch_word[c]), .aux(ch_aux[c]), .len(word_len),
      .aux_en(aux_en), .slot(ch_slot[c])
    );
    // channel 0 takes the high slot so that it leaves first
    assign par_frame[REG_W-1-c*SLOT_W -: SLOT_W] = ch_slot[c];
  end

  tdm_frame_gen #(.PERIOD(PERIOD)) u_fgen (
    .clk(clk), .rst(rst), .master_en(master_en), .pulse(gen_pulse)
  );

  assign load      = master_en ? gen_pulse : frame_in;
  assign frame_out = gen_pulse;

  tdm_shift_reg #(.W(REG_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .par_in(par_frame),
    .ser_in(tdm_in), .q(frame_bits), .ser_out(sdata_out)
  );
endmodule

// File: rtl/tdm_chain_node_chk.sv
`timescale 1ns/1ps
module tdm_chain_node_chk #(
  parameter int SLOT_W    = 32,
  parameter int AUX_W     = 8,
  parameter int WORD_MIN  = 16,
  parameter int CHAIN_LEN = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           master_en,
  input logic                           frame_in,
  input logic                           frame_out,
  input logic [$clog2(SLOT_W-AUX_W+1)-1:0] word_len,
  input logic [SLOT_W-AUX_W-1:0]        left_word,
  input logic                           sdata_out,
  input logic [2*SLOT_W-1:0]            shreg
);
  localparam int WORD_MAX = SLOT_W - AUX_W;
  localparam int LEN_W    = $clog2(WORD_MAX + 1);
  localparam int REG_W    = 2 * SLOT_W;
  localparam int PERIOD   = CHAIN_LEN * REG_W;
  localparam int GW       = $clog2(PERIOD) + 1;

  logic           ld;
  logic [LEN_W-1:0] len_c;
  logic           left_msb;
  logic [GW-1:0]  gap;
  logic           seen;

  assign ld = master_en ? frame_out : frame_in;

  always_comb begin
    if (word_len < LEN_W'(WORD_MIN))      len_c = LEN_W'(WORD_MIN);
    else if (word_len > LEN_W'(WORD_MAX)) len_c = LEN_W'(WORD_MAX);
    else                                  len_c = word_len;
  end
  assign left_msb = left_word[len_c - 1'b1];

  always_ff @(posedge clk) begin
    if (rst || !master_en) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (frame_out) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != GW'(PERIOD)) begin
      gap <= gap + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sdata_out && !frame_out)); // R1
  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (rst) ld |=> (sdata_out == $past(left_msb))); // R2
  AST_SHIFT_THROUGH: assert property (@(posedge clk) disable iff (rst) !ld |=> (sdata_out == $past(shreg[REG_W-2]))); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst) frame_out |=> !frame_out); // R8
  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (rst) (seen && master_en) |-> (frame_out == (gap == GW'(PERIOD-1)))); // R8
  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (rst) !master_en |=> !frame_out); // R9
endmodule

bind tdm_chain_node tdm_chain_node_chk #(
  .SLOT_W(SLOT_W), .AUX_W(AUX_W), .WORD_MIN(WORD_MIN), .CHAIN_LEN(CHAIN_LEN)
) u_chk (
  .clk(clk), .rst(rst), .master_en(master_en), .frame_in(frame_in),
  .frame_out(frame_out), .word_len(word_len), .left_word(left_word),
  .sdata_out(sdata_out), .shreg(frame_bits)
);

// File: tb/sim_tdm_chain_node.sv
`timescale 1ns/1ps
module sim_tdm_chain_node;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        m_en0 = 1'b0;
  logic        fin0  = 1'b0;
  logic        tail  = 1'b0;
  logic [23:0] lw [4];
  logic [23:0] rw [4];
  logic [7:0]  la [4];
  logic [7:0]  ra [4];
  logic [4:0]  wl [4];
  logic        ae [4];
  logic        sd [4];
  logic        fo [4];

  tdm_chain_node u0 (.clk(clk), .rst(rst), .master_en(m_en0), .frame_in(fin0), .frame_out(fo[0]),
    .word_len(wl[0]), .aux_en(ae[0]), .left_word(lw[0]), .right_word(rw[0]), .left_aux(la[0]),
    .right_aux(ra[0]), .tdm_in(sd[1]), .sdata_out(sd[0]));
  tdm_chain_node u1 (.clk(clk), .rst(rst), .master_en(1'b0), .frame_in(fo[0]), .frame_out(fo[1]),
    .word_len(wl[1]), .aux_en(ae[1]), .left_word(lw[1]), .right_word(rw[1]), .left_aux(la[1]),
    .right_aux(ra[1]), .tdm_in(sd[2]), .sdata_out(sd[1]));
  tdm_chain_node u2 (.clk(clk), .rst(rst), .master_en(1'b0), .frame_in(fo[0]), .frame_out(fo[2]),
    .word_len(wl[2]), .aux_en(ae[2]), .left_word(lw[2]), .right_word(rw[2]), .left_aux(la[2]),
    .right_aux(ra[2]), .tdm_in(sd[3]), .sdata_out(sd[2]));
  tdm_chain_node u3 (.clk(clk), .rst(rst), .master_en(1'b0), .frame_in(fo[0]), .frame_out(fo[3]),
    .word_len(wl[3]), .aux_en(ae[3]), .left_word(lw[3]), .right_word(rw[3]), .left_aux(la[3]),
    .right_aux(ra[3]), .tdm_in(tail), .sdata_out(sd[3]));

  typedef struct { int cyc; logic val; string req; } item_t;
  item_t sbq[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: compares sdata_out of the host-side node against stamped expectations
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      if (it.cyc != cyc) check(1'b0, it.req, 64'(cyc), 64'(it.cyc));
      else check(sd[0] === it.val, it.req, 64'(sd[0]), 64'(it.val));
    end
  end

  function automatic logic [31:0] exp_slot(logic [23:0] s, logic [7:0] a, logic [4:0] len, logic en);
    int L;
    logic [31:0] r;
    L = (len < 5'd16) ? 16 : (len > 5'd24) ? 24 : int'(len);
    r = '0;
    for (int j = 0; j < L; j++) r[31-j] = s[L-1-j];
    if (en) r[7:0] = a;
    return r;
  endfunction

  // driver: push the expected bits of one node's frame starting at cycle base
  task automatic push_node(input int base, input int n, input string req, input string req_last);
    logic [63:0] f;
    f = {exp_slot(lw[n], la[n], wl[n], ae[n]), exp_slot(rw[n], ra[n], wl[n], ae[n])};
    for (int b = 0; b < 64; b++) begin
      item_t it;
      it.cyc = base + b;
      it.val = f[63-b];
      it.req = (b == 63) ? req_last : req;
      sbq.push_back(it);
    end
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
  endtask

  task automatic set_node(input int n, input logic [23:0] l, input logic [23:0] r,
                          input logic [7:0] al, input logic [7:0] ar, input logic [4:0] len, input logic en);
    lw[n] = l; rw[n] = r; la[n] = al; ra[n] = ar; wl[n] = len; ae[n] = en;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int c;
    int prev;
    bit fo_seen;
    for (int n = 0; n < 4; n++) set_node(n, '0, '0, '0, '0, 5'd16, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sd[0] === 1'b0 && fo[0] === 1'b0, "R1", {62'd0, sd[0], fo[0]}, 64'd0);
    rst = 1'b0;

    // slave, no frames: the whole chain is one 256-bit delay line (R6, R9)
    fo_seen = 1'b0;
    for (int k = 0; k < 600; k++) begin
      item_t it;
      @(negedge clk);
      if (fo[0] !== 1'b0) fo_seen = 1'b1;
      tail = 1'($urandom % 2);
      it.cyc = cyc + 256;
      it.val = tail;
      it.req = "R6";
      sbq.push_back(it);
    end
    drain();
    check(!fo_seen, "R9", 64'(fo_seen), 64'd0);

    // slave load from frame_in; stream of ones behind it (R2, R3, R7, R9)
    tail = 1'b1;
    repeat (260) @(negedge clk);
    set_node(0, 24'hA5C3E7, 24'h3C5A96, 8'hFF, 8'hFF, 5'd20, 1'b0);
    @(negedge clk);
    fin0 = 1'b1;
    c = cyc + 1;
    push_node(c, 0, "R2", "R7");
    for (int b = 64; b < 96; b++) begin
      item_t it;
      it.cyc = c + b;
      it.val = 1'b1;
      it.req = "R6";
      sbq.push_back(it);
    end
    @(negedge clk);
    fin0 = 1'b0;
    drain();

    // master mode, four-node chain (R3, R4, R5, R8, R10)
    tail = 1'b0;
    set_node(0, 24'h123456, 24'hFEDCBA, 8'h5A, 8'hC3, 5'd16, 1'b0);
    set_node(1, 24'h89ABCD, 24'h13579B, 8'hA6, 8'h3D, 5'd20, 1'b1);
    set_node(2, 24'hF0F0F1, 24'h0F0F0E, 8'h81, 8'h7E, 5'd24, 1'b1);
    set_node(3, 24'h7FFF81, 24'h00FFFF, 8'h11, 8'hEE, 5'd13, 1'b0);
    m_en0 = 1'b1;
    prev = -1;
    for (int fr = 0; fr < 3; fr++) begin
      do @(negedge clk); while (fo[0] !== 1'b1);
      if (prev >= 0) check(cyc - prev == 256, "R8", 64'(cyc - prev), 64'd256);
      prev = cyc;
      c = cyc + 1;
      push_node(c,       0, "R10", "R10");
      push_node(c + 64,  1, "R5",  "R5");
      push_node(c + 128, 2, "R3",  "R3");
      push_node(c + 192, 3, "R4",  "R4");
      @(negedge clk);
      check(fo[0] === 1'b0, "R8", 64'(fo[0]), 64'd0);
      if (fr == 0) begin
        set_node(0, 24'h0000FF, 24'hFFFF00, 8'h96, 8'h69, 5'd31, 1'b1);
        set_node(1, 24'hC0FFEE, 24'hBEEF01, 8'h00, 8'hFF, 5'd18, 1'b0);
        set_node(2, 24'h000001, 24'h800000, 8'h42, 8'h24, 5'd24, 1'b1);
        set_node(3, 24'h00AAAA, 24'h005555, 8'hF0, 8'h0F, 5'd16, 1'b1);
      end else begin
        set_node(0, 24'h5A5A5A, 24'hA5A5A5, 8'h3C, 8'hC3, 5'd22, 1'b1);
        set_node(1, 24'hFFFFFF, 24'h000000, 8'hAA, 8'h55, 5'd0,  1'b1);
      end
      if (fr == 1) begin
        // frame_in pulses in master mode must be ignored (R8)
        repeat (40) @(negedge clk);
        fin0 = 1'b1;
        @(negedge clk);
        fin0 = 1'b0;
        repeat (60) @(negedge clk);
        fin0 = 1'b1;
        @(negedge clk);
        fin0 = 1'b0;
      end
    end
    drain();

    // back to slave: no generated pulses (R9)
    m_en0 = 1'b0;
    @(negedge clk);
    fo_seen = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (fo[0] !== 1'b0) fo_seen = 1'b1;
    end
    check(!fo_seen, "R9", 64'(fo_seen), 64'd0);

    summary();
  end
endmodule